// File: doc/BRIEF.md
# Pipelined Burst Data Memory

This block is a 64-bit-wide synchronous data store for a secondary cache. Each access starts from an address that the memory captures when the address strobe is low and the part is selected. After that first beat an internal two-bit counter generates the remaining three beat addresses inside an aligned four-word line. The counter can walk the line in linear order, adding one modulo 4, or in interleaved order, where each beat's low bits are the start bits XOR a count. A count-enable input either advances the burst or holds it at its current beat.

Writes take effect on the rising clock edge. Two active-low enables each guard one 32-bit half of the word. Reads are pipelined: the word for an access registered at one edge is presented on the next edge. The read data leaves the block on a data port plus a separate bus-drive flag, and that flag is gated by an asynchronous active-low output enable. The memory depth is set by an address-width parameter: 15 address bits give 32K words and 16 give 64K words.

Top module: `burst_sram`

## Requirements
- R1: When `strobe_n` is 0 and `sel_n` is 1 at a clock edge, the burst ends, no address is captured and no access happens. Two edges later `rdata_oe` is 0. While the burst is ended, `cnt_en_n` has no effect.
- R2: When `strobe_n` and `sel_n` are both 0 at an edge, an access begins at `addr` and the beat count restarts at 0. If `wr_n` is 2'b11 the access is a read; any bit of `wr_n` at 0 makes it a write.
- R3: During an active burst with `strobe_n` at 1, `cnt_en_n` at 0 moves the access to the next burst address. `cnt_en_n` at 1 repeats the current address. Either case may be a read or a write, as selected by `wr_n`.
- R4: With `order_il` at 0, the two low address bits of the beats are start+0, +1, +2, +3 modulo 4. The upper address bits stay fixed.
- R5: With `order_il` at 1, the two low address bits of beat k are the start bits XOR k, for k = 0,1,2,3.
- R6: `rdata_oe` follows `oe_n` without a clock edge. It can be 1 only while `oe_n` is 0.
- R7: A write access at an edge leaves `rdata_oe` at 0 two edges later, whatever `oe_n` is.
- R8: `wr_n[0]` at 0 writes `wdata[31:0]` and `wr_n[1]` at 0 writes `wdata[63:32]`. A half whose enable is 1 keeps its old contents.
- R9: For a read access at edge E, `rdata` holds the stored word after edge E+1, and `rdata_oe` is 1 then if `oe_n` is 0.
- R10: A read access that repeats the current beat (suspend) does not reload `rdata`, so the data register keeps its value through the suspend.
- R11: A synchronous `rst` at 1 ends any burst, clears the beat count and the bus-drive state, and zeroes `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | Address strobe, active low |
| sel_n | input | 1 | Standby / select; 1 deselects when strobed |
| cnt_en_n | input | 1 | Burst advance, active low; 1 suspends |
| wr_n | input | 2 | Write enables per 32-bit half, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address captured at burst start |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Pipelined read data |
| rdata_oe | output | 1 | Bus drive enable for rdata |

## Verification
The bench sweeps every start offset of a line in both burst orders. A counter that wraps past the line boundary, or that adds where it should XOR, returns data from the wrong word. Half-word writes are checked against the untouched half, so an enable wired to the wrong half shows up as corrupted data. A suspend placed in the middle of a read burst would expose a data register that reloads or a counter that still moves. Further checks cover bus release after a deselect or a write, an output enable that waits for a clock, and a reset in the middle of a burst that fails to stop the counter.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    localparam int unsigned BEAT_W = 2;

    // Low address bits of a beat, given the captured start bits and beat count.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] count,
        input burst_order_e      order
    );
        if (order == ORDER_INTERLEAVED) begin
            return start ^ count;
        end
        return start + count;
    endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  strobe_n,
    input  logic                  sel_n,
    input  logic                  cnt_en_n,
    input  logic [1:0]            wr_n,
    input  logic                  order_il,
    input  logic [ADDR_W-1:0]     addr,
    output logic [ADDR_W-1:0]     acc_addr,
    output logic [1:0]            wr_en,
    output logic [ADDR_W-1:0]     rd_addr_q,
    output logic                  rd_load_q,
    output logic                  drive_q,
    output logic [BEAT_W-1:0]     beat_q,
    output logic                  active_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
        logic              active;
        logic [ADDR_W-1:0] rd_addr;
        logic              rd_load;
        logic              rd_pend;
        logic              drive;
    } seq_state_t;

    seq_state_t st_q, st_d;
    logic       access;
    logic       suspend;
    logic       rd_now;

    always_comb begin
        st_d    = st_q;
        access  = 1'b0;
        suspend = 1'b0;
        if (!strobe_n && !sel_n) begin
            st_d.base   = addr;
            st_d.cnt    = '0;
            st_d.active = 1'b1;
            access      = 1'b1;
        end else if (!strobe_n) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            access = 1'b1;
            if (cnt_en_n) begin
                suspend = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        acc_addr = {st_d.base[ADDR_W-1:BEAT_W],
                    beat_low(st_d.base[BEAT_W-1:0], st_d.cnt, burst_order_e'(order_il))};
        wr_en        = access ? ~wr_n : 2'b00;
        rd_now       = access && (&wr_n);
        st_d.rd_addr = rd_now ? acc_addr : st_q.rd_addr;
        st_d.rd_load = rd_now && !suspend;
        st_d.rd_pend = rd_now;
        st_d.drive   = st_q.rd_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_q = st_q.rd_addr;
    assign rd_load_q = st_q.rd_load;
    assign drive_q   = st_q.drive;
    assign beat_q    = st_q.cnt;
    assign active_q  = st_q.active;

endmodule

// File: rtl/half_bank.sv
module half_bank #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [HALF_W-1:0] mem [DEPTH];
    logic [HALF_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wdata;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_load) begin
            rd_d = mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic              sel_n,
    input  logic              cnt_en_n,
    input  logic [1:0]        wr_n,
    input  logic              order_il,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    localparam int unsigned HALVES = 2;
    localparam int unsigned HALF_W = DATA_W / HALVES;

    logic [ADDR_W-1:0] acc_addr;
    logic [1:0]        wr_en;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_load_q;
    logic              drive_q;
    logic [BEAT_W-1:0] beat_q;
    logic              active_q;

    burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe_n  (strobe_n),
        .sel_n     (sel_n),
        .cnt_en_n  (cnt_en_n),
        .wr_n      (wr_n),
        .order_il  (order_il),
        .addr      (addr),
        .acc_addr  (acc_addr),
        .wr_en     (wr_en),
        .rd_addr_q (rd_addr_q),
        .rd_load_q (rd_load_q),
        .drive_q   (drive_q),
        .beat_q    (beat_q),
        .active_q  (active_q)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        half_bank #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[h]),
            .wr_addr (acc_addr),
            .wdata   (wdata[h*HALF_W +: HALF_W]),
            .rd_load (rd_load_q),
            .rd_addr (rd_addr_q),
            .rdata   (rdata[h*HALF_W +: HALF_W])
        );
    end

    assign rdata_oe = drive_q & ~oe_n;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic       clk,
    input logic       rst,
    input logic       strobe_n,
    input logic       sel_n,
    input logic       cnt_en_n,
    input logic [1:0] wr_n,
    input logic       rdata_oe,
    input logic [1:0] beat,
    input logic       active
);

    a_r1_desel_release: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && sel_n) |=> ##1 !rdata_oe);

    a_r1_desel_ends: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && sel_n) |=> !active);

    a_r2_begin_restart: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !sel_n) |=> (active && beat == 2'd0));

    a_r3_suspend_hold: assert property (@(posedge clk) disable iff (rst)
        (strobe_n && cnt_en_n) |=> $stable(beat));

    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (active && strobe_n && !cnt_en_n) |=> beat == 2'($past(beat) + 2'd1));

    a_r7_write_release: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !sel_n && wr_n != 2'b11) |=> ##1 !rdata_oe);

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!active && beat == 2'd0 && !rdata_oe));

endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (strobe_n),
    .sel_n    (sel_n),
    .cnt_en_n (cnt_en_n),
    .wr_n     (wr_n),
    .rdata_oe (rdata_oe),
    .beat     (beat_q),
    .active   (active_q)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/100ps
module burst_sram_test;

    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_n = 1'b1;
    logic          sel_n = 1'b1;
    logic          cnt_en_n = 1'b1;
    logic [1:0]    wr_n = 2'b11;
    logic          order_il = 1'b0;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [63:0]   wdata = '0;
    logic [63:0]   rdata;
    logic          rdata_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .DATA_W(64)) uut (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .sel_n(sel_n),
        .cnt_en_n(cnt_en_n), .wr_n(wr_n), .order_il(order_il), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // {order, start[1:0], beat0..beat3 low bits}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 2'b00, 8'b00_01_10_11},
        {1'b0, 2'b01, 8'b01_10_11_00},
        {1'b0, 2'b10, 8'b10_11_00_01},
        {1'b0, 2'b11, 8'b11_00_01_10},
        {1'b1, 2'b00, 8'b00_01_10_11},
        {1'b1, 2'b01, 8'b01_00_11_10},
        {1'b1, 2'b10, 8'b10_11_00_01},
        {1'b1, 2'b11, 8'b11_10_01_00}
    };

    function automatic logic [63:0] pat(input logic [AW-1:0] a);
        return {16'hC0DE, 8'h00, a, 16'h51A7, 8'hFF, ~a};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_single(input logic [AW-1:0] a, input logic [63:0] d, input logic [1:0] w);
        strobe_n = 1'b0; sel_n = 1'b0; wr_n = w; addr = a; wdata = d;
        tick();
        wr_n = 2'b11;
    endtask

    task automatic deselect();
        strobe_n = 1'b0; sel_n = 1'b1; wr_n = 2'b11;
        tick();
        strobe_n = 1'b1; cnt_en_n = 1'b1;
    endtask

    // begin a read, suspend once, return data present after the load edge
    task automatic rd_single(input logic [AW-1:0] a, output logic [63:0] d);
        strobe_n = 1'b0; sel_n = 1'b0; wr_n = 2'b11; addr = a;
        tick();
        strobe_n = 1'b1; cnt_en_n = 1'b1;
        tick();
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic [AW-1:0] base;
        repeat (3) tick();
        chk("R11 reset oe", 64'(rdata_oe), 64'd0);
        chk("R11 reset data", rdata, 64'd0);
        rst = 1'b0;
        tick();

        // table of burst orders
        for (int v = 0; v < 8; v++) begin
            base = AW'((v + 4) << 2);
            for (int k = 0; k < 4; k++) wr_single(base | AW'(k), pat(base | AW'(k)), 2'b00);
            order_il = VEC[v][10];
            oe_n = 1'b0;
            strobe_n = 1'b0; sel_n = 1'b0; wr_n = 2'b11; addr = base | AW'(VEC[v][9:8]);
            tick();
            strobe_n = 1'b1; cnt_en_n = 1'b0;
            for (int b = 0; b < 4; b++) begin
                if (b == 3) cnt_en_n = 1'b1;
                tick();
                if (b == 0) chk("R9 first beat drive", 64'(rdata_oe), 64'd1);
                chk(VEC[v][10] ? "R5 interleaved beat" : "R4 linear beat",
                    rdata, pat(base | AW'(VEC[v][7-2*b -: 2])));
            end
            deselect();
        end
        order_il = 1'b0;

        // R8 half writes
        wr_single(8'h80, 64'h1111_1111_2222_2222, 2'b00);
        wr_single(8'h80, 64'hAAAA_AAAA_BBBB_BBBB, 2'b10);
        rd_single(8'h80, got);
        chk("R8 low half only", got, 64'h1111_1111_BBBB_BBBB);
        wr_single(8'h80, 64'hCCCC_CCCC_DDDD_DDDD, 2'b01);
        rd_single(8'h80, got);
        chk("R8 high half only", got, 64'hCCCC_CCCC_BBBB_BBBB);

        // R6 asynchronous output enable
        oe_n = 1'b1; #0.5;
        chk("R6 oe high releases", 64'(rdata_oe), 64'd0);
        oe_n = 1'b0; #0.5;
        chk("R6 oe low drives", 64'(rdata_oe), 64'd1);
        deselect();

        // R3 write burst, linear from 0x92, and R7 bus release
        strobe_n = 1'b0; sel_n = 1'b0; wr_n = 2'b00; addr = 8'h92; wdata = 64'hE0;
        tick();
        strobe_n = 1'b1; cnt_en_n = 1'b0; wdata = 64'hE1;
        tick();
        chk("R7 write releases bus", 64'(rdata_oe), 64'd0);
        wdata = 64'hE2; tick();
        wdata = 64'hE3; tick();
        deselect();
        rd_single(8'h92, got); chk("R3 write beat0", got, 64'hE0);
        rd_single(8'h93, got); chk("R3 write beat1", got, 64'hE1);
        rd_single(8'h90, got); chk("R3 write beat2", got, 64'hE2);
        rd_single(8'h91, got); chk("R3 write beat3", got, 64'hE3);
        deselect();

        // R10 suspend in a read burst from 0x90 (linear)
        strobe_n = 1'b0; sel_n = 1'b0; wr_n = 2'b11; addr = 8'h90;
        tick();
        strobe_n = 1'b1; cnt_en_n = 1'b0; tick();
        cnt_en_n = 1'b1; tick();
        tick();
        chk("R10 suspend holds data", rdata, 64'hE3);
        cnt_en_n = 1'b0; tick();
        tick();
        chk("R3 continue after suspend", rdata, 64'hE0);
        deselect();

        // R1 deselect mid-burst, address ignored, count enable ignored
        strobe_n = 1'b0; sel_n = 1'b0; addr = 8'h90;
        tick();
        strobe_n = 1'b1; cnt_en_n = 1'b0; tick();
        chk("R9 burst drives", 64'(rdata_oe), 64'd1);
        strobe_n = 1'b0; sel_n = 1'b1; addr = 8'h80; tick();
        strobe_n = 1'b1; cnt_en_n = 1'b0; tick();
        chk("R1 released after deselect", 64'(rdata_oe), 64'd0);
        got = rdata;
        tick(); tick();
        chk("R1 count enable ignored oe", 64'(rdata_oe), 64'd0);
        chk("R1 count enable ignored data", rdata, got);
        cnt_en_n = 1'b1;

        // R11 reset mid-burst
        strobe_n = 1'b0; sel_n = 1'b0; addr = 8'h90;
        tick();
        strobe_n = 1'b1; cnt_en_n = 1'b0; tick();
        rst = 1'b1; tick();
        rst = 1'b0;
        chk("R11 reset mid-burst oe", 64'(rdata_oe), 64'd0);
        chk("R11 reset mid-burst data", rdata, 64'd0);
        tick(); tick();
        chk("R11 no burst after reset", 64'(rdata_oe), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule